// File: doc/BRIEF.md
# Subcarrier Manchester Response Decoder

This block turns the modulation-detect stream of a tag's reply into bytes. Samples come four to a nibble. Bit 3 of each nibble is the earliest sample and bit 0 the latest. One nibble covers half a bit period, so a bit period is two accepted nibbles. While idle, the decoder locks onto the sample position of the first modulated sample and confirms that the start burst is long. It then checks a three-period start pattern and decodes data bits. The polarity is reversed from the common convention. Bytes are assembled least-significant bit first. A period modulated in both halves closes the frame.

Each finished byte appears on the byte outputs for one cycle together with its odd-parity flag. At the end marker, a final partial byte of two or more bits is right-aligned and emitted with a parity flag of 0, and a single leftover bit is dropped. A one-cycle done pulse then reports the byte count of the frame. Frame timeouts and CRC checks belong to the surrounding controller.

The controller is a state machine with these states:
- ST_IDLE: waits for any modulated sample.
- ST_BURST: confirms the burst on the next nibble.
- ST_SOF2 and ST_SOF3: the two second-half-only start periods.
- ST_DATA: decodes bits.
- ST_ERR: a one-period penalty.

It makes these transitions:
- IDLE→BURST on a hit.
- BURST→SOF2 if the burst holds, BURST→IDLE if it does not.
- SOF2→SOF3 and SOF3→DATA on a second-half-only period.
- SOF2→ERR and SOF3→ERR on anything else.
- DATA→DATA on a data bit.
- DATA→IDLE on a good end marker.
- DATA→ERR on an empty period or on an end marker with no bytes.
- ERR→IDLE after one bit period.

Top module: `mcd_top`

## Requirements
- R1: While reset is held and after it is released, byte_vld, byte_data, byte_par, frame_done, frame_len and sync_ofs are all zero.
- R2: While idle, the highest-numbered set bit of an accepted nibble is taken as the sync position, and sync_ofs reports that index (3 down to 0). Every later nibble of the frame is judged only by its bit at that position, so other bits have no effect.
- R3: If the nibble after the sync nibble is not modulated at the sync position, the decoder returns silently to idle and produces no output.
- R4: The start of frame must be three bit periods: both halves modulated, then second half only, then second half only. Any other pattern enters the error state and no bytes are produced.
- R5: In data, a period modulated only in its second half is a 1 and a period modulated only in its first half is a 0. The first bit received lands in bit 0 of the byte.
- R6: After every 8 data bits, one byte_vld pulse carries the byte, with byte_par = 1 exactly when the byte has an even number of ones.
- R7: A period modulated in both halves is the end marker. If k ≥ 2 bits are pending, they are emitted right-aligned in bits k-1..0, upper bits 0, with byte_par = 0, in the same cycle as frame_done. If k = 1, the bit is discarded.
- R8: frame_done is a one-cycle pulse with frame_len equal to the number of bytes emitted in the frame, partial byte included. A frame that would have zero bytes gives no done pulse and enters the error state.
- R9: A data period with no modulation in either half enters the error state. Bytes already emitted stand, and no done pulse follows.
- R10: The error state consumes exactly one bit period (two accepted nibbles), whatever they contain, and then returns to idle. The next accepted nibble can start a new frame.
- R11: Cycles with nib_vld low change nothing, whatever nib holds.
- R12: Every return to idle clears the byte count and the pending bits, so back-to-back frames are counted independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_vld | input | 1 | nib holds a new group of samples |
| nib | input | SPN (4) | Modulation-detect samples, bit SPN-1 earliest |
| byte_vld | output | 1 | One-cycle strobe for byte_data and byte_par |
| byte_data | output | BW (8) | Decoded byte, first bit received in bit 0 |
| byte_par | output | 1 | Odd-parity flag for a full byte, 0 for a partial byte |
| frame_done | output | 1 | One-cycle pulse at a good end of frame |
| frame_len | output | LEN_W (8) | Byte count of the last completed frame |
| sync_ofs | output | log2(SPN) (2) | Sample position chosen at sync |

## Verification
A wrong state or phase in this decoder shows at the ports within one or two bit periods. A half-period slip swaps 0s and 1s or turns data into end markers, so byte_data is wrong on the next byte strobe. A stuck error or sync state shows as a missing done pulse, or as a frame_len that disagrees with the bits sent, at the end of that same frame. Sending a frame straight after an error period shows an error period that is too long or too short: the following frame is lost or decoded wrongly.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_SOF2,
        ST_SOF3,
        ST_DATA,
        ST_ERR
    } mcd_state_e;

    // {first half modulated, second half modulated}
    typedef enum logic [1:0] {
        HV_NONE   = 2'b00,
        HV_SECOND = 2'b01,
        HV_FIRST  = 2'b10,
        HV_BOTH   = 2'b11
    } mcd_half_e;

endpackage

// File: rtl/mcd_sync_pick.sv
module mcd_sync_pick #(
    parameter int SPN = 4,
    localparam int PW = (SPN > 1) ? $clog2(SPN) : 1
) (
    input  logic [SPN-1:0] nib,
    output logic           hit,
    output logic [PW-1:0]  pos
);
    // Highest index is the earliest sample; later loop iterations win.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = 0; i < SPN; i++) begin
            if (nib[i]) begin
                hit = 1'b1;
                pos = PW'(i);
            end
        end
    end
endmodule

// File: rtl/mcd_half_pair.sv
module mcd_half_pair
    import mcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      step,
    input  logic      mod_in,
    output logic      period_end,
    output mcd_half_e cls
);
    logic phase;
    logic first_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase   <= 1'b0;
            first_q <= 1'b0;
        end else if (step) begin
            phase <= ~phase;
            if (!phase) first_q <= mod_in;
        end
    end

    assign period_end = step && phase;
    assign cls        = mcd_half_e'({first_q, mod_in});
endmodule

// File: rtl/mcd_byte_asm.sv
module mcd_byte_asm #(
    parameter int BW = 8,
    localparam int SW = BW + 1,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          bit_in,
    output logic          full,
    output logic [BW-1:0] full_byte,
    output logic [CW-1:0] cnt,
    output logic [BW-1:0] part_byte
);
    localparam logic [CW-1:0] SW_C   = CW'(SW);
    localparam logic [CW-1:0] LAST_C = CW'(BW - 1);

    logic [SW-1:0] sr;
    logic [SW-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (push) begin
            sr  <= {bit_in, sr[SW-1:1]};
            cnt <= full ? '0 : cnt + 1'b1;
        end
    end

    assign full      = push && (cnt == LAST_C);
    assign full_byte = {bit_in, sr[SW-1:2]};
    assign sh        = sr >> (SW_C - cnt);
    assign part_byte = sh[BW-1:0];
endmodule

// File: rtl/mcd_top.sv
module mcd_top
    import mcd_pkg::*;
#(
    parameter int SPN   = 4,
    parameter int BW    = 8,
    parameter int LEN_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 nib_vld,
    input  logic [SPN-1:0]                       nib,
    output logic                                 byte_vld,
    output logic [BW-1:0]                        byte_data,
    output logic                                 byte_par,
    output logic                                 frame_done,
    output logic [LEN_W-1:0]                     frame_len,
    output logic [((SPN > 1) ? $clog2(SPN) : 1)-1:0] sync_ofs
);
    localparam int PW = (SPN > 1) ? $clog2(SPN) : 1;
    localparam int CW = $clog2(BW + 1);

    mcd_state_e state, nxt;

    logic          hit;
    logic [PW-1:0] pos_c, pos_q;
    logic          mod;
    logic          h_clear, h_step, period_end;
    mcd_half_e     cls;
    logic          push, bit_val, full;
    logic [BW-1:0] full_byte, part_byte;
    logic [CW-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic          eof, part_ok, eof_good;

    mcd_sync_pick #(.SPN(SPN)) u_pick (
        .nib (nib),
        .hit (hit),
        .pos (pos_c)
    );

    assign mod     = nib[pos_q];
    assign h_clear = (state == ST_IDLE) || (state == ST_BURST);
    assign h_step  = nib_vld && !h_clear;

    mcd_half_pair u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (h_clear),
        .step       (h_step),
        .mod_in     (mod),
        .period_end (period_end),
        .cls        (cls)
    );

    assign push    = (state == ST_DATA) && period_end &&
                     ((cls == HV_FIRST) || (cls == HV_SECOND));
    assign bit_val = (cls == HV_SECOND);

    mcd_byte_asm #(.BW(BW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_IDLE),
        .push      (push),
        .bit_in    (bit_val),
        .full      (full),
        .full_byte (full_byte),
        .cnt       (cnt),
        .part_byte (part_byte)
    );

    assign eof      = (state == ST_DATA) && period_end && (cls == HV_BOTH);
    assign part_ok  = (cnt > CW'(1));
    assign eof_good = eof && ((len != '0) || part_ok);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (nib_vld && hit) nxt = ST_BURST;
            ST_BURST: if (nib_vld) nxt = mod ? ST_SOF2 : ST_IDLE;
            ST_SOF2:  if (period_end) nxt = (cls == HV_SECOND) ? ST_SOF3 : ST_ERR;
            ST_SOF3:  if (period_end) nxt = (cls == HV_SECOND) ? ST_DATA : ST_ERR;
            ST_DATA: begin
                if (period_end) begin
                    unique case (cls)
                        HV_FIRST, HV_SECOND: nxt = ST_DATA;
                        HV_BOTH:             nxt = eof_good ? ST_IDLE : ST_ERR;
                        HV_NONE:             nxt = ST_ERR;
                    endcase
                end
            end
            ST_ERR:   if (period_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            byte_par   <= 1'b0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            sync_ofs   <= '0;
            pos_q      <= '0;
            len        <= '0;
        end else begin
            byte_vld   <= 1'b0;
            frame_done <= 1'b0;
            if (state == ST_IDLE) begin
                len <= '0;
                if (nib_vld && hit) begin
                    pos_q    <= pos_c;
                    sync_ofs <= pos_c;
                end
            end
            if (full) begin
                byte_vld  <= 1'b1;
                byte_data <= full_byte;
                byte_par  <= ~^full_byte;
                len       <= len + 1'b1;
            end
            if (eof_good) begin
                frame_done <= 1'b1;
                frame_len  <= len + LEN_W'(part_ok);
                if (part_ok) begin
                    byte_vld  <= 1'b1;
                    byte_data <= part_byte;
                    byte_par  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mcd_chk.sv
module mcd_chk #(
    parameter int BW    = 8,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nib_vld,
    input logic             byte_vld,
    input logic [BW-1:0]    byte_data,
    input logic             byte_par,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len
);
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(nib_vld) |-> (!byte_vld && !frame_done))
        else $error("p_quiet_r11");

    p_full_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !frame_done) |-> (byte_par == ~^byte_data))
        else $error("p_full_par_r6");

    p_part_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && frame_done) |-> !byte_par)
        else $error("p_part_par_r7");

    p_len_nz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_len != '0))
        else $error("p_len_nz_r8");

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("p_pulse_r8");
endmodule

bind mcd_top mcd_chk #(.BW(BW), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_vld    (nib_vld),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .byte_par   (byte_par),
    .frame_done (frame_done),
    .frame_len  (frame_len)
);

// File: tb/mcd_top_test.sv
module mcd_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_vld = 1'b0;
    logic [3:0] nib = 4'h0;
    logic       byte_vld, byte_par, frame_done;
    logic [7:0] byte_data, frame_len;
    logic [1:0] sync_ofs;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit gaps = 0, noise = 0;

    logic [7:0] got_b [0:1023];
    logic       got_p [0:1023];
    int         got_n = 0, done_n = 0;
    logic [7:0] last_len;
    logic [1:0] last_ofs;
    bit         tx_bits [0:63];

    always #5 clk = ~clk;

    mcd_top uut (
        .clk(clk), .rst_n(rst_n), .nib_vld(nib_vld), .nib(nib),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_par(byte_par),
        .frame_done(frame_done), .frame_len(frame_len), .sync_ofs(sync_ofs)
    );

    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            got_b[got_n % 1024] = byte_data;
            got_p[got_n % 1024] = byte_par;
            got_n++;
        end
        if (rst_n && frame_done) begin
            done_n++;
            last_len = frame_len;
            last_ofs = sync_ofs;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] mk(input int p, input bit m);
        logic [3:0] v;
        v = m ? 4'(1 << p) : 4'h0;
        if (noise) v = v | (4'($urandom) & 4'((1 << p) - 1));
        return v;
    endfunction

    task automatic put(input logic [3:0] v);
        if (gaps && ($urandom % 5 == 0)) begin
            nib_vld = 1'b0;
            nib = 4'($urandom);
            @(negedge clk);
        end
        nib_vld = 1'b1;
        nib = v;
        @(negedge clk);
        nib_vld = 1'b0;
        nib = 4'h0;
    endtask

    task automatic per(input int p, input bit f, input bit s);
        put(mk(p, f));
        put(mk(p, s));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(4'h0);
    endtask

    task automatic body(input int p, input int n);
        per(p, 1, 1); per(p, 0, 1); per(p, 0, 1);
        for (int i = 0; i < n; i++) begin
            if (tx_bits[i]) per(p, 0, 1);
            else            per(p, 1, 0);
        end
    endtask

    // Sends a good frame of n bits from tx_bits and checks all outputs.
    task automatic run_frame(input int p, input int n, input int pre, input string tag);
        int b0, d0, nfull, k, en;
        logic [7:0] eb;
        b0 = got_n; d0 = done_n;
        idle(pre);
        body(p, n);
        per(p, 1, 1);
        idle(4);
        nfull = n / 8; k = n % 8;
        en = nfull + ((k >= 2) ? 1 : 0);
        chk(got_n - b0 == en, {tag, " byte count"}, got_n - b0, en);
        for (int i = 0; i < en && i < got_n - b0; i++) begin
            int nb;
            nb = (i < nfull) ? 8 : k;
            eb = 8'h00;
            for (int j = 0; j < nb; j++) eb[j] = tx_bits[8 * i + j];
            chk(got_b[(b0 + i) % 1024] == eb, {tag, " R5 byte"}, got_b[(b0 + i) % 1024], eb);
            chk(got_p[(b0 + i) % 1024] == ((i < nfull) ? ~^eb : 1'b0), {tag, " R6/R7 parity"},
                got_p[(b0 + i) % 1024], (i < nfull) ? ~^eb : 1'b0);
        end
        chk(done_n - d0 == ((en > 0) ? 1 : 0), {tag, " R8 done"}, done_n - d0, (en > 0) ? 1 : 0);
        if (en > 0) begin
            chk(last_len == 8'(en), {tag, " R8/R12 frame_len"}, last_len, en);
            chk(last_ofs == 2'(p), {tag, " R2 sync_ofs"}, last_ofs, p);
        end
    endtask

    task automatic set_bytes(input logic [7:0] a, input logic [7:0] b);
        for (int j = 0; j < 8; j++) begin
            tx_bits[j] = a[j];
            tx_bits[8 + j] = b[j];
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int b0, d0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk({byte_vld, byte_data, byte_par, frame_done, frame_len, sync_ofs} == '0,
            "R1 reset outputs", {byte_vld, frame_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({byte_vld, byte_data, byte_par, frame_done, frame_len, sync_ofs} == '0,
            "R1 after reset", {byte_vld, frame_done}, 0);

        // R5 R6: two full bytes at earliest position
        set_bytes(8'hA5, 8'h3C);
        run_frame(3, 16, 2, "R5 two bytes");
        // R7 partial byte of three bits
        set_bytes(8'h0F, 8'h05);
        run_frame(0, 11, 2, "R7 partial");
        // R7 single leftover bit discarded
        set_bytes(8'h81, 8'h01);
        run_frame(1, 9, 2, "R7 lone bit");
        // R8 zero-byte frames
        run_frame(2, 0, 2, "R8 empty");
        run_frame(2, 1, 2, "R8 one bit");

        // R2 noise below the sync position
        noise = 1;
        set_bytes(8'h6E, 8'hD1);
        run_frame(2, 16, 2, "R2 noise");
        noise = 0;

        // R4 bad second start period (both halves)
        b0 = got_n; d0 = done_n;
        idle(2); per(3, 1, 1); per(3, 1, 1); per(3, 0, 1);
        for (int i = 0; i < 8; i++) per(3, 0, 1);
        per(3, 1, 1); idle(4);
        chk(got_n == b0 && done_n == d0, "R4 bad SOF2", got_n - b0, 0);
        // R4 bad third start period (first half only)
        b0 = got_n; d0 = done_n;
        idle(2); per(1, 1, 1); per(1, 0, 1); per(1, 1, 0);
        for (int i = 0; i < 8; i++) per(1, 1, 0);
        per(1, 1, 1); idle(4);
        chk(got_n == b0 && done_n == d0, "R4 bad SOF3", got_n - b0, 0);

        // R3 short burst rejected, then a good frame
        b0 = got_n; d0 = done_n;
        put(4'h4); idle(3);
        chk(got_n == b0 && done_n == d0, "R3 short burst", got_n - b0, 0);
        set_bytes(8'h5A, 8'h00);
        run_frame(0, 8, 1, "R3 after reject");

        // R9 empty data period after one byte
        b0 = got_n; d0 = done_n;
        idle(2); per(2, 1, 1); per(2, 0, 1); per(2, 0, 1);
        for (int i = 0; i < 8; i++) per(2, 0, 1);
        per(2, 0, 0); per(2, 1, 1); idle(4);
        chk(got_n - b0 == 1, "R9 byte kept", got_n - b0, 1);
        chk(done_n == d0, "R9 no done", done_n - d0, 0);

        // R10 error lasts exactly one period: modulated garbage inside it, frame right after
        idle(2); per(3, 1, 1); per(3, 1, 1);   // SOF2 fails -> error
        per(3, 1, 1);                          // consumed by error period
        set_bytes(8'hC3, 8'h96);
        run_frame(2, 16, 0, "R10 after error");

        // R11 invalid cycles with random contents
        gaps = 1;
        set_bytes(8'h3E, 8'h71);
        run_frame(1, 13, 2, "R11 gaps");

        // R12 random frames, back to back
        for (int f = 0; f < 60; f++) begin
            int p, n;
            p = $urandom % 4;
            n = $urandom % 41;
            noise = ($urandom % 2) == 1;
            for (int i = 0; i < n; i++) tx_bits[i] = ($urandom % 2) == 1;
            run_frame(p, n, $urandom % 3, "R12 random");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule